// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that completes every instruction in one clock cycle. It holds a program counter, a register file of 32 words with two combinational read ports and one write port, an immediate extender, an adder/subtractor/OR unit, a hand-written instruction decoder and the multiplexers that steer operands and results. Its instruction store and data store are small internal word arrays. A loader port writes either array and reads either one back.

The usual flow is as follows. Hold `rst` high while loading the program and the initial data through the loader port. Release `rst` and let the core run for a number of cycles. Then read the data array back. The decoder first sorts each instruction into one of eight kinds: add, sub, ori, lw, sw, beq, j, or no-op. A single `unique case` over that kind then sets the multiplexer selects: destination field, ALU operand source, write-back source, branch and jump selects, and extend type.

A register write, a data-array write and the program-counter update all take effect on the same rising edge. Everything the core reads within a cycle is read combinationally.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and the core writes neither the register file nor the data array. `pc_o` reads 0 after that edge.
- R2: R-type instructions have opcode bits [31:26] = 000000, rs in [25:21], rt in [20:16], rd in [15:11] and funct in [5:0]. Funct 100000 writes R[rs]+R[rt] to rd, and funct 100010 writes R[rs]-R[rt] to rd, both modulo 2^32. The PC then advances by 4.
- R3: ori (opcode 001101, rs [25:21], rt [20:16], imm [15:0]) writes R[rs] OR the zero-extended immediate to rt.
- R4: lw (opcode 100011) writes to rt the data word at byte address R[rs] + sign-extended imm. The word index is byte address bits [7:2].
- R5: sw (opcode 101011) writes R[rt] to the data word at byte address R[rs] + sign-extended imm, and writes no register. It is the only instruction that writes the data array.
- R6: beq (opcode 000100) subtracts R[rt] from R[rs]. If the result is zero, the next PC is PC+4+(sign-extended imm << 2); otherwise it is PC+4. beq writes neither a register nor memory, and backward offsets are supported.
- R7: j (opcode 000010) sets the PC to {(PC+4)[31:28], instr[25:0], 2'b00}.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Any other opcode, or an R-type funct other than the two above, behaves as a no-op. It writes no register and no memory, and the PC advances by 4.
- R10: An instruction that reads and writes the same register uses the value from before the edge, and the next instruction sees the new value.
- R11: With `ld_we` high, `ld_wdata` is written at the rising edge to word `ld_addr` of the data array if `ld_dmem`=1, or of the instruction array if `ld_dmem`=0. `ld_rdata` shows that word combinationally. A loader write takes precedence over a core store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Loader write strobe |
| ld_dmem | input | 1 | Loader target: 1 data array, 0 instruction array |
| ld_addr | input | LDAW (6) | Loader word index |
| ld_wdata | input | 32 | Loader write word |
| ld_rdata | output | 32 | Word at `ld_addr` in the selected array |
| pc_o | output | 32 | Current program counter |

## Verification
The core reads a register and writes the same register at the same edge whenever an instruction names one register both as a source and as its destination. The bench provokes this with a chain of `add r2,r2,r2` after seeding r2 with 3. It judges the result by storing r2 and reading the word back: the value must be exactly 12, since a read that saw the new value early or a write that was lost would give a different number. Branch resolution and the PC update also fall in one cycle. The bench covers this with taken, not-taken and backward-looping beq, and compares `pc_o` and the stored words against hand-computed targets.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_JMP   = 6'b000010;
    localparam logic [5:0] FN_ADD   = 6'b100000;
    localparam logic [5:0] FN_SUB   = 6'b100010;

    typedef enum logic [2:0] {
        K_NOP, K_ADD, K_SUB, K_ORI, K_LW, K_SW, K_BEQ, K_JMP
    } kind_t;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } aluop_t;

    typedef struct packed {
        logic   dst_rd;
        logic   src_imm;
        logic   wb_mem;
        logic   rf_we;
        logic   dm_we;
        logic   is_beq;
        logic   is_jmp;
        logic   ext_sign;
        aluop_t alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    kind_t kind;

    always_comb begin
        kind = K_NOP;
        unique case (op)
            OP_RTYPE: begin
                if (funct == FN_ADD)      kind = K_ADD;
                else if (funct == FN_SUB) kind = K_SUB;
                else                      kind = K_NOP;
            end
            OP_ORI:  kind = K_ORI;
            OP_LW:   kind = K_LW;
            OP_SW:   kind = K_SW;
            OP_BEQ:  kind = K_BEQ;
            OP_JMP:  kind = K_JMP;
            default: kind = K_NOP;
        endcase
    end

    always_comb begin
        ctrl = '0;
        unique case (kind)
            K_ADD: begin
                ctrl.dst_rd = 1'b1;
                ctrl.rf_we  = 1'b1;
                ctrl.alu_op = ALU_ADD;
            end
            K_SUB: begin
                ctrl.dst_rd = 1'b1;
                ctrl.rf_we  = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            K_ORI: begin
                ctrl.src_imm = 1'b1;
                ctrl.rf_we   = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            K_LW: begin
                ctrl.src_imm  = 1'b1;
                ctrl.wb_mem   = 1'b1;
                ctrl.rf_we    = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.alu_op   = ALU_ADD;
            end
            K_SW: begin
                ctrl.src_imm  = 1'b1;
                ctrl.dm_we    = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.alu_op   = ALU_ADD;
            end
            K_BEQ: begin
                ctrl.is_beq   = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.alu_op   = ALU_SUB;
            end
            K_JMP: ctrl.is_jmp = 1'b1;
            K_NOP: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] cells [NREG];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) cells[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : cells[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : cells[raddr_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  aluop_t       op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW  = $clog2(IMEM_WORDS),
    localparam int DAW  = $clog2(DMEM_WORDS),
    localparam int LDAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_we,
    input  logic            ld_dmem,
    input  logic [LDAW-1:0] ld_addr,
    input  logic [31:0]     ld_wdata,
    output logic [31:0]     ld_rdata,
    output logic [31:0]     pc_o
);

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [31:0] pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    logic [31:0] instr, ext_imm, rd_a, rd_b, alu_b, alu_y, dm_rdata, wb_data;
    logic [4:0]  f_rs, f_rt, f_rd, rf_waddr;
    logic        alu_zero, rf_we, dm_we;
    logic [DAW-1:0] dm_idx;
    ctrl_t       ctrl;

    assign instr = imem[pc_q[IAW+1:2]];
    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];

    sc_decoder u_dec (
        .op    (instr[31:26]),
        .funct (instr[5:0]),
        .ctrl  (ctrl)
    );

    assign rf_waddr = ctrl.dst_rd ? f_rd : f_rt;
    assign rf_we    = ctrl.rf_we & ~rst;
    assign dm_we    = ctrl.dm_we & ~rst;

    sc_regfile #(.NREG(32), .W(32)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (wb_data),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    assign ext_imm = ctrl.ext_sign ? {{16{instr[15]}}, instr[15:0]}
                                   : {16'b0, instr[15:0]};
    assign alu_b   = ctrl.src_imm ? ext_imm : rd_b;

    sc_alu #(.W(32)) u_alu (
        .a    (rd_a),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign dm_idx   = alu_y[DAW+1:2];
    assign dm_rdata = dmem[dm_idx];
    assign wb_data  = ctrl.wb_mem ? dm_rdata : alu_y;

    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {ext_imm[29:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.is_jmp)                  pc_next = jmp_tgt;
        else if (ctrl.is_beq && alu_zero) pc_next = br_tgt;
        else                              pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    always_ff @(posedge clk) begin
        if (ld_we && !ld_dmem) imem[ld_addr[IAW-1:0]] <= ld_wdata;
    end

    always_ff @(posedge clk) begin
        if (ld_we && ld_dmem) dmem[ld_addr[DAW-1:0]] <= ld_wdata;
        else if (dm_we)       dmem[dm_idx] <= rd_b;
    end

    assign ld_rdata = ld_dmem ? dmem[ld_addr[DAW-1:0]] : imem[ld_addr[IAW-1:0]];
    assign pc_o     = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic        dm_we,
    input logic [31:0] rd_a
);

    logic [5:0] op, fn;
    logic       legal;
    assign op = instr[31:26];
    assign fn = instr[5:0];
    assign legal = (op == 6'h00 && (fn == 6'h20 || fn == 6'h22)) ||
                   op == 6'h0D || op == 6'h23 || op == 6'h2B ||
                   op == 6'h04 || op == 6'h02;

    assert_pc_reset_R1: assert property (@(posedge clk) rst |=> pc == 32'd0);

    assert_no_write_in_reset_R1: assert property (@(posedge clk)
        rst |-> (!rf_we && !dm_we));

    assert_store_only_R5: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> op == 6'h2B);

    assert_beq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        op == 6'h04 |-> (!rf_we && !dm_we));

    assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
        op == 6'h02 |=> pc == ((($past(pc) + 32'd4) & 32'hF000_0000) |
                               {4'b0, $past(instr[25:0]), 2'b00}));

    assert_r0_zero_R8: assert property (@(posedge clk) disable iff (rst)
        instr[25:21] == 5'd0 |-> rd_a == 32'd0);

    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !legal |-> (!rf_we && !dm_we));

    assert_nop_advance_R9: assert property (@(posedge clk) disable iff (rst)
        !legal |=> pc == $past(pc) + 32'd4);

endmodule

bind sc_core sc_core_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .pc    (pc_q),
    .instr (instr),
    .rf_we (rf_we),
    .dm_we (dm_we),
    .rd_a  (rd_a)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_wdata = '0;
    logic [31:0] ld_rdata, pc_o;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    sc_core dut (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata), .pc_o(pc_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(int word);
        return {6'h02, 26'(word)};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic put(logic dm, int idx, logic [31:0] w);
        ld_we = 1'b1; ld_dmem = dm; ld_addr = 6'(idx); ld_wdata = w;
        @(posedge clk); #1;
        ld_we = 1'b0;
    endtask

    task automatic peek(logic dm, int idx, output logic [31:0] w);
        ld_dmem = dm; ld_addr = 6'(idx);
        #1 w = ld_rdata;
    endtask

    task automatic run(int n);
        rst = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic halt();
        rst = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [31:0] w;
        rst = 1'b1;
        put(1, 0, 32'hDEAD_BEEF);
        put(0, 0, enc_i(6'h2B, 0, 0, 16'h0000));
        repeat (3) @(posedge clk);
        #1;
        check("R1 pc in reset", pc_o, 32'd0);
        peek(1, 0, w); check("R1 no store in reset", w, 32'hDEAD_BEEF);
        peek(0, 0, w); check("R11 imem readback", w, enc_i(6'h2B, 0, 0, 16'h0000));
        put(1, 63, 32'h0123_4567);
        peek(1, 63, w); check("R11 dmem readback", w, 32'h0123_4567);
    endtask

    task automatic t_arith();
        logic [31:0] w;
        put(0, 0, enc_i(6'h0D, 0, 1, 16'h1234));
        put(0, 1, enc_i(6'h0D, 0, 2, 16'hFFFF));
        put(0, 2, enc_r(1, 2, 3, 6'h20));
        put(0, 3, enc_r(1, 2, 4, 6'h22));
        put(0, 4, enc_i(6'h2B, 0, 2, 16'd0));
        put(0, 5, enc_i(6'h2B, 0, 3, 16'd4));
        put(0, 6, enc_i(6'h2B, 0, 4, 16'd8));
        put(0, 7, enc_j(7));
        run(10);
        check("R7 self jump pc", pc_o, 32'd28);
        halt();
        check("R1 pc after reset", pc_o, 32'd0);
        peek(1, 0, w); check("R3 ori zero-extend", w, 32'h0000_FFFF);
        peek(1, 1, w); check("R2 add", w, 32'h0001_1233);
        peek(1, 2, w); check("R2 sub wraps", w, 32'hFFFF_1235);
    endtask

    task automatic t_mem();
        logic [31:0] w;
        put(1, 5, 32'hCAFE_F00D);
        put(1, 6, 32'h1111_1111);
        put(1, 7, 32'h0);
        put(1, 9, 32'h0);
        put(0, 0, enc_i(6'h0D, 0, 1, 16'h0020));
        put(0, 1, enc_i(6'h23, 1, 2, 16'hFFF4));
        put(0, 2, enc_i(6'h2B, 1, 2, 16'hFFFC));
        put(0, 3, enc_i(6'h2B, 0, 2, 16'd36));
        put(0, 4, enc_j(4));
        run(8);
        halt();
        peek(1, 7, w); check("R4/R5 lw then sw negative offset", w, 32'hCAFE_F00D);
        peek(1, 9, w); check("R5 sw positive offset", w, 32'hCAFE_F00D);
        peek(1, 6, w); check("R5 neighbour untouched", w, 32'h1111_1111);
    endtask

    task automatic t_branch();
        logic [31:0] w;
        put(1, 0, 32'h0);
        put(1, 1, 32'h0);
        put(0, 0, enc_i(6'h0D, 0, 1, 16'd5));
        put(0, 1, enc_i(6'h0D, 0, 2, 16'd5));
        put(0, 2, enc_i(6'h04, 1, 2, 16'd2));
        put(0, 3, enc_i(6'h0D, 0, 3, 16'h0BAD));
        put(0, 4, enc_i(6'h2B, 0, 3, 16'd0));
        put(0, 5, enc_i(6'h0D, 0, 4, 16'd7));
        put(0, 6, enc_i(6'h04, 1, 4, 16'd5));
        put(0, 7, enc_i(6'h0D, 0, 5, 16'h600D));
        put(0, 8, enc_i(6'h2B, 0, 5, 16'd4));
        put(0, 9, enc_i(6'h04, 0, 0, 16'hFFFF));
        run(12);
        check("R6 backward beq loop", pc_o, 32'd36);
        halt();
        peek(1, 0, w); check("R6 taken beq skips store", w, 32'h0);
        peek(1, 1, w); check("R6 not-taken beq falls through", w, 32'h0000_600D);
    endtask

    task automatic t_jump();
        logic [31:0] w;
        put(1, 0, 32'h0);
        put(0, 0, enc_j(3));
        put(0, 1, enc_i(6'h0D, 0, 1, 16'h0BAD));
        put(0, 2, enc_i(6'h2B, 0, 1, 16'd0));
        put(0, 3, enc_i(6'h0D, 0, 2, 16'h0077));
        put(0, 4, enc_i(6'h2B, 0, 2, 16'd4));
        put(0, 5, enc_j(5));
        run(6);
        check("R7 jump lands", pc_o, 32'd20);
        halt();
        peek(1, 0, w); check("R7 jumped-over store", w, 32'h0);
        peek(1, 1, w); check("R7 target executes", w, 32'h0000_0077);
    endtask

    task automatic t_r0();
        logic [31:0] w;
        put(1, 0, 32'hFFFF_FFFF);
        put(0, 0, enc_i(6'h0D, 0, 0, 16'h0055));
        put(0, 1, enc_r(0, 0, 0, 6'h20));
        put(0, 2, enc_i(6'h2B, 0, 0, 16'd0));
        put(0, 3, enc_j(3));
        run(5);
        halt();
        peek(1, 0, w); check("R8 r0 stays zero", w, 32'h0);
    endtask

    task automatic t_nop();
        logic [31:0] w;
        put(1, 0, 32'h0000_AAAA);
        put(1, 1, 32'h0);
        put(0, 0, enc_i(6'h0D, 0, 1, 16'h0042));
        put(0, 1, enc_i(6'h3F, 0, 1, 16'h0099));
        put(0, 2, enc_r(0, 0, 1, 6'h25));
        put(0, 3, enc_i(6'h28, 0, 1, 16'h0000));
        put(0, 4, enc_i(6'h2B, 0, 1, 16'd4));
        put(0, 5, enc_j(5));
        run(4);
        check("R9 no-ops advance pc", pc_o, 32'd16);
        run(3);
        halt();
        peek(1, 0, w); check("R9 no-op no store", w, 32'h0000_AAAA);
        peek(1, 1, w); check("R9 no-op no reg write", w, 32'h0000_0042);
    endtask

    task automatic t_same_reg();
        logic [31:0] w;
        put(1, 2, 32'h0);
        put(0, 0, enc_i(6'h0D, 0, 2, 16'd3));
        put(0, 1, enc_r(2, 2, 2, 6'h20));
        put(0, 2, enc_r(2, 2, 2, 6'h20));
        put(0, 3, enc_i(6'h2B, 0, 2, 16'd8));
        put(0, 4, enc_j(4));
        run(6);
        halt();
        peek(1, 2, w); check("R10 read-old write-new", w, 32'd12);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_arith();
        t_mem();
        t_branch();
        t_jump();
        t_r0();
        t_nop();
        t_same_reg();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule